// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver

This block is the receive side of a clocked synchronous serial port that moves 8-bit frames. It can run as the clock source, driving its own transfer clock at a fixed division of the system clock. It can also run as a clock follower, taking bits on an external transfer clock while an active-low select input is held low. Incoming bits are shifted in most significant bit first on the rising edge of the transfer clock. A completed byte is placed in a holding register, a full flag is raised, and an interrupt request can follow.

Software drives the block through a small register port with three addresses. Address 0 is the read-only byte holder. Address 1 holds the status flags: bit 0 full (read-only), bit 1 overrun, bit 2 conflict. Writing 0 to bit 1 or bit 2 clears that flag, and writing 1 leaves it as it is. Address 2 is the control register: bit 0 receive enable, bit 1 interrupt enable, bit 2 clock-source mode (1 means the block drives the clock). Reception is armed only when the enable is set and software then reads address 0 once as a dummy access. The block flags an overrun when a byte completes on top of an unread one. In follower mode it keeps apart a read that races a new byte, which raises the conflict flag, from a read that comes too late, which loses the byte with no flag at all.

Top module: `serial_rx_ctrl`

## Requirements
- R1: After reset, or while the enable bit (control bit 0) is 1 but no read of address 0 has yet been made, no bit is received, and in clock-source mode `sclk_out` stays low.
- R2: In follower mode (control bit 2 = 0), bits are taken only on rising edges of `sclk_in` that occur while `sel_n_in` is low. Edges seen while `sel_n_in` is high leave the full flag at 0.
- R3: Bits are taken most significant first. On the 8th bit the byte is loaded into address 0 and status bit 0 (full) becomes 1.
- R4: `irq_out` is high exactly while the full flag is 1 and the interrupt enable (control bit 1) is 1.
- R5: A read of address 0 clears the full flag on the next cycle.
- R6: In clock-source mode, if the full flag is already 1 when the 8th bit of a new byte arrives, status bit 1 (overrun) becomes 1, the new byte is dropped and the held byte is kept.
- R7: While the overrun flag is 1, no reception takes place and `sclk_out` stays low. Writing 0 to status bit 1 restarts reception without a new dummy read.
- R8: In follower mode, if a byte begins while the full flag is 1 and address 0 is read before that byte ends, status bit 2 (conflict) becomes 1 when it ends, and the byte is dropped.
- R9: In follower mode, if a byte begins while the full flag is 1 and address 0 is not read before it ends, the byte is dropped, both the overrun and conflict flags stay 0, and the held byte is kept.
- R10: Writing the enable bit to 0 disarms the block. Setting it to 1 again needs a fresh dummy read before reception resumes.
- R11: In clock-source mode `sclk_out` has a period of 2*HALF_DIV system clocks, with high and low phases of HALF_DIV cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register address: 0 byte, 1 status, 2 control |
| reg_wdata | input | 3 | Write data (only three low bits are defined) |
| reg_rdata | output | 8 | Read data for the addressed register |
| sclk_in | input | 1 | External transfer clock (follower mode) |
| sel_n_in | input | 1 | Active-low select (follower mode) |
| sdata_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Transfer clock driven in clock-source mode |
| irq_out | output | 1 | Receive interrupt request |

## Verification
The assertions watch the flag logic on every cycle. The full flag may only rise on a byte completion. A data read must drop it. The overrun flag may only rise when a byte completes while the flag is full. The conflict flag may only rise on a follower-mode completion. No byte completes while the block is unarmed, and the driven clock stays low while unarmed or halted. Other behaviours can only be shown by the bench scenarios with real bit streams: the bit order and byte contents, the clock period, the choice between a conflict and a silent loss in back-to-back follower bytes, the restart after an overrun is cleared, and the need for a fresh dummy read after the block is disabled.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    localparam int FRAME_BITS = 8;

    localparam logic [1:0] ADDR_BYTE = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef struct packed {
        logic                  rx_en;
        logic                  irq_en;
        logic                  master;
        logic                  armed;
        logic                  full;
        logic                  ovr;
        logic                  cfl;
        logic                  began_full;  // follower byte began while full
        logic                  read_mid;    // byte register read during that byte
        logic                  sclk_prev;
        logic [FRAME_BITS-1:0] hold;
    } ctl_st_t;

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= rst_val;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ssrx_mclk.sv
module ssrx_mclk #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } mclk_st_t;

    mclk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk     = st_q.sclk;
    assign rise_stb = run && (st_q.cnt == LAST) && !st_q.sclk;

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  stb,
    input  logic                  bit_i,
    output logic                  start,
    output logic                  done,
    output logic [FRAME_BITS-1:0] frame
);

    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-2:0] sh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   take;

    assign take = stb && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (stb) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            st_d.sh  = {st_q.sh[FRAME_BITS-3:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = take && (st_q.cnt == '0);
    assign done  = take && (st_q.cnt == LAST);
    assign frame = {st_q.sh, bit_i};

endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
    import ssrx_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [2:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sclk_in,
    input  logic       sel_n_in,
    input  logic       sdata_in,
    output logic       sclk_out,
    output logic       irq_out
);

    ctl_st_t st_d, st_q;

    logic [2:0]            pins_s;
    logic                  s_sclk, s_sel_n, s_sdat;
    logic                  active, m_run, m_rise, sl_rise;
    logic                  bit_stb, bit_val, shift_clr;
    logic                  f_start, f_done;
    logic [FRAME_BITS-1:0] f_byte;
    logic                  rd_byte, wr_stat, wr_ctrl;

    ssrx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_in, sel_n_in, sdata_in}),
        .rst_val (3'b010),
        .sync_o  (pins_s)
    );

    assign {s_sclk, s_sel_n, s_sdat} = pins_s;

    assign active = st_q.armed && st_q.rx_en && !st_q.ovr;
    assign m_run  = active && st_q.master;

    ssrx_mclk #(
        .HALF_DIV (HALF_DIV)
    ) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (m_run),
        .sclk     (sclk_out),
        .rise_stb (m_rise)
    );

    assign sl_rise   = !st_q.master && s_sclk && !st_q.sclk_prev && !s_sel_n;
    assign bit_stb   = st_q.master ? m_rise : sl_rise;
    assign bit_val   = st_q.master ? sdata_in : s_sdat;
    assign shift_clr = !active || (!st_q.master && s_sel_n);

    ssrx_shift #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (shift_clr),
        .stb   (bit_stb),
        .bit_i (bit_val),
        .start (f_start),
        .done  (f_done),
        .frame (f_byte)
    );

    assign rd_byte = reg_rd && (reg_addr == ADDR_BYTE);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = s_sclk;

        if (wr_ctrl) begin
            st_d.rx_en  = reg_wdata[0];
            st_d.irq_en = reg_wdata[1];
            st_d.master = reg_wdata[2];
        end
        if (wr_stat) begin
            st_d.ovr = st_q.ovr & reg_wdata[1];
            st_d.cfl = st_q.cfl & reg_wdata[2];
        end

        if (rd_byte) begin
            st_d.full = 1'b0;
            if (st_q.rx_en) st_d.armed = 1'b1;
        end
        if (!st_q.rx_en) st_d.armed = 1'b0;

        if (f_start) begin
            st_d.began_full = st_q.full && !st_q.master;
            st_d.read_mid   = rd_byte;
        end else if (rd_byte) begin
            st_d.read_mid = 1'b1;
        end

        if (f_done) begin
            if (st_q.began_full) begin
                if (st_q.read_mid || rd_byte) st_d.cfl = 1'b1;
            end else if (st_q.full) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.hold = f_byte;
                st_d.full = 1'b1;
            end
            st_d.began_full = 1'b0;
            st_d.read_mid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_BYTE: reg_rdata = st_q.hold;
            ADDR_STAT: reg_rdata = {5'd0, st_q.cfl, st_q.ovr, st_q.full};
            ADDR_CTRL: reg_rdata = {5'd0, st_q.master, st_q.irq_en, st_q.rx_en};
            default:   reg_rdata = 8'd0;
        endcase
    end

    assign irq_out = st_q.full && st_q.irq_en;

endmodule

// File: rtl/serial_rx_ctrl_chk.sv
module serial_rx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic armed,
    input logic full,
    input logic ovr,
    input logic cfl,
    input logic master,
    input logic done,
    input logic rd_byte,
    input logic sclk_out
);

    p_no_byte_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !done);

    p_clock_idle_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && $past(!armed)) |-> !sclk_out);

    p_full_from_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(done));

    p_read_drops_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte && !done) |=> !full);

    p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(done) && $past(full)));

    p_halt_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && $past(ovr)) |-> !sclk_out);

    p_conflict_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfl) |-> ($past(done) && !$past(master)));

endmodule

bind serial_rx_ctrl serial_rx_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (st_q.armed),
    .full     (st_q.full),
    .ovr      (st_q.ovr),
    .cfl      (st_q.cfl),
    .master   (st_q.master),
    .done     (f_done),
    .rd_byte  (rd_byte),
    .sclk_out (sclk_out)
);

// File: tb/serial_rx_ctrl_bench.sv
`timescale 1ns/1ps
module serial_rx_ctrl_bench;

    localparam int HALF_DIV = 4;
    localparam int NVEC = 6;
    // each entry: {byte sent, byte expected at address 0}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5A5, 16'h3C3C, 16'hFFFF, 16'h0000, 16'h8181, 16'h7E7E
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [2:0] reg_wdata = 3'd0;
    logic [7:0] reg_rdata;
    logic       sclk_in = 1'b0, sel_n_in = 1'b1, sdata_in;
    logic       sclk_out, irq_out;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;

    logic       drv_master = 1'b1;
    logic       sdata_sl = 1'b0;
    logic [7:0] mbytes [16];
    logic [3:0] mfrm = 4'd0;
    logic [2:0] mbit = 3'd0;

    always #2 clk = ~clk;

    serial_rx_ctrl #(.HALF_DIV(HALF_DIV)) u_serial_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_in(sclk_in), .sel_n_in(sel_n_in), .sdata_in(sdata_in),
        .sclk_out(sclk_out), .irq_out(irq_out)
    );

    // clock-source mode data driver: next bit presented right after each rise
    always @(posedge sclk_out) begin
        if (mbit == 3'd7) begin
            mbit <= 3'd0;
            mfrm <= mfrm + 4'd1;
        end else begin
            mbit <= mbit + 3'd1;
        end
    end
    assign sdata_in = drv_master ? mbytes[mfrm][3'd7 - mbit] : sdata_sl;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [2:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(input logic [7:0] mask, output logic [7:0] s);
        s = 8'd0;
        for (int i = 0; i < 3000; i++) begin
            peek(2'd1, s);
            if ((s & mask) != 8'd0) break;
        end
    endtask

    task automatic sl_bits(input logic [7:0] b, input int from, input int upto);
        for (int i = from; i <= upto; i++) begin
            sdata_sl = b[7 - i];
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
    endtask

    task automatic sl_byte(input logic [7:0] b);
        sel_n_in = 1'b0;
        repeat (4) @(negedge clk);
        sl_bits(b, 0, 7);
        repeat (6) @(negedge clk);
        sel_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       sclk_seen;
        realtime    t0, t1;
        for (int i = 0; i < NVEC; i++) mbytes[i] = VEC[i][15:8];
        mbytes[6] = 8'h11; mbytes[7] = 8'h22; mbytes[8] = 8'h99;
        for (int i = 9; i < 16; i++) mbytes[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        peek(2'd1, v); check("R1 reset status", v, 8'h00);
        peek(2'd0, v); check("R1 reset byte", v, 8'h00);
        check("R4 reset irq", {7'd0, irq_out}, 8'h00);

        // R1: enable without dummy read keeps the clock idle
        wr(2'd2, 3'b111);
        sclk_seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); sclk_seen |= sclk_out;
        end
        check("R1 no clock before dummy read", {7'd0, sclk_seen}, 8'h00);

        rd(2'd0, v);  // dummy read arms reception
        // vector table walk in clock-source mode
        for (int k = 0; k < NVEC; k++) begin
            wait_stat(8'h01, v);
            check("R3 full after byte", v, 8'h01);
            check("R4 irq with full", {7'd0, irq_out}, 8'h01);
            rd(2'd0, v);
            check("R3 byte value", v, VEC[k][7:0]);
            peek(2'd1, v);
            check("R5 read clears full", v & 8'h01, 8'h00);
            if (k == 0) begin
                @(posedge sclk_out); t0 = $realtime;
                @(posedge sclk_out); t1 = $realtime;
                check("R11 clock period", 8'(int'((t1 - t0) / 4.0)), 8'(2 * HALF_DIV));
            end
        end

        // R6/R7: leave 0x11 unread, 0x22 overruns
        wait_stat(8'h02, v);
        check("R6 overrun flagged", v, 8'h03);
        sclk_seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); sclk_seen |= sclk_out;
        end
        check("R7 clock halted", {7'd0, sclk_seen}, 8'h00);
        rd(2'd0, v);
        check("R6 held byte kept", v, 8'h11);
        wr(2'd1, 3'b000);
        peek(2'd1, v);
        check("R7 overrun cleared", v, 8'h00);
        wait_stat(8'h01, v);
        rd(2'd0, v);
        check("R7 resume after clear", v, 8'h99);

        // R10: disable then re-enable without dummy read
        wr(2'd2, 3'b000);
        wr(2'd2, 3'b101);
        sclk_seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); sclk_seen |= sclk_out;
        end
        check("R10 re-enable needs dummy read", {7'd0, sclk_seen}, 8'h00);
        wr(2'd2, 3'b000);

        // follower mode, interrupt disabled
        drv_master = 1'b0;
        wr(2'd2, 3'b001);
        rd(2'd0, v);
        sl_byte(8'h5A);
        peek(2'd1, v);
        check("R2 follower byte received", v, 8'h01);
        check("R4 irq masked", {7'd0, irq_out}, 8'h00);
        rd(2'd0, v);
        check("R3 follower byte value", v, 8'h5A);

        // R2: edges with select high are ignored
        sel_n_in = 1'b1;
        sl_bits(8'hC3, 0, 7);
        repeat (6) @(negedge clk);
        peek(2'd1, v);
        check("R2 select high ignored", v, 8'h00);

        // R8: read races a new byte
        sl_byte(8'h6B);
        sel_n_in = 1'b0;
        repeat (4) @(negedge clk);
        sl_bits(8'hD4, 0, 3);
        rd(2'd0, v);
        check("R8 racing read returns held byte", v, 8'h6B);
        sl_bits(8'hD4, 4, 7);
        repeat (6) @(negedge clk);
        sel_n_in = 1'b1;
        repeat (4) @(negedge clk);
        peek(2'd1, v);
        check("R8 conflict set, byte dropped", v, 8'h04);
        wr(2'd1, 3'b000);

        // R9: late read loses the byte silently
        sl_byte(8'h2E);
        sl_byte(8'hE2);
        peek(2'd1, v);
        check("R9 no overrun or conflict", v, 8'h01);
        rd(2'd0, v);
        check("R9 held byte kept", v, 8'h2E);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule